// File: doc/BRIEF.md
# Sv32 Page Permission Fault Checker

This block sits after a two-level page walker in a 32-bit paged memory path. For every access it receives the walk outcome (whether a leaf entry was found, and the low permission field of that leaf), the kind of access, whether translation is active, and four machine status controls. It decides whether the access may proceed. If it may not, it reports a page-fault exception, with a cause code that depends on the kind of access and with the virtual address as the trap value.

The decision is registered, so each request gets one result on the following clock edge. In bare mode the checker never faults. When translation is on, several conditions can each cause a fault: a walk that found no leaf, a malformed leaf, a permission the access lacks, or a user page touched during a supervisor-effective machine access without the user-access override. Only one cause code is reported per access.

Top module: `pgf_check`

## Requirements
- R1: A result appears on the rsp_ port group exactly one clock after a cycle with req_valid high. When req_valid was low, rsp_valid, rsp_fault, rsp_cause and rsp_tval are all zero.
- R2: The cause of a fault depends only on req_kind: 00 (fetch) gives 12, 01 (load) gives 13, 10 (store) gives 15, and 11 is handled as a load (checks and cause 13).
- R3: When xlate_on is low (bare mode), no fault is reported, whatever the walk and status inputs are.
- R4: When xlate_on is high and walk_hit is low, the access faults.
- R5: A leaf whose valid bit (pte_flags bit 0) is clear, or whose write bit (bit 2) is set while its read bit (bit 1) is clear, faults for every kind.
- R6: A fetch faults unless the leaf's execute bit (bit 3) is set.
- R7: A load faults unless the read bit is set, or st_mxr is high and the execute bit is set.
- R8: A store faults unless the write bit is set.
- R9: When st_mprv is high and st_mpp is 01, a leaf with its user bit (bit 4) set faults unless st_sum is high. With any other st_mpp value, or with st_mprv low, the user bit causes no fault.
- R10: On a fault, rsp_tval equals the request's vaddr. Without a fault, rsp_cause and rsp_tval are zero.
- R11: While rst_n is low at a clock edge, all outputs are cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| xlate_on | input | 1 | Paged translation active |
| walk_hit | input | 1 | Walk found a leaf entry |
| pte_flags | input | 5 | Leaf bits 4:0: U, X, W, R, V |
| vaddr | input | VA_W | Virtual address of the access |
| st_mxr | input | 1 | Execute-implies-readable control |
| st_sum | input | 1 | Permit supervisor access to user pages |
| st_mprv | input | 1 | Machine accesses use the privilege in st_mpp |
| st_mpp | input | 2 | Previous privilege field (01 = supervisor) |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 5 | Exception cause, zero if no fault |
| rsp_tval | output | VA_W | Trap value, zero if no fault |

## Verification
The vector table covers these cases: an execute-only page read with and without the readable override, a write-only (reserved) leaf, a user page under a supervisor-effective access with the override both clear and set, and a user page under other previous-privilege values. A design that tested the user bit without also checking the previous-privilege field would fault wrongly in that last case. A design that ignored the override would refuse the execute-only read. Bare-mode rows carry a missing walk and a zero leaf, which catches a checker that forgets the bare mode. Kind 11 and store rows catch swapped cause codes. An idle request carrying fault-worthy inputs checks that no result leaks out without a strobe.

// File: rtl/pgf_pkg.sv
// Shared encodings for the page fault checker.
// Assumes the leaf permission field uses bits 4:0 as U, X, W, R, V.
package pgf_pkg;
    localparam int FLAG_W  = 5;
    localparam int CAUSE_W = 5;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_U = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PF = 5'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = 5'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = 5'd15;

    localparam logic [1:0] MPP_SUPER = 2'b01;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_LOAD2 = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
        logic v;
    } leaf_bits_t;
endpackage

// File: rtl/pgf_leaf_decode.sv
// Splits the leaf permission field and flags malformed encodings.
// Assumes the field layout from pgf_pkg; a leaf is malformed when it is
// not valid or when it grants write without read.
module pgf_leaf_decode
    import pgf_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    output leaf_bits_t        bits,
    output logic              malformed
);
    // Name the individual bits and evaluate the reserved encodings.
    always_comb begin
        bits.v    = flags[BIT_V];
        bits.r    = flags[BIT_R];
        bits.w    = flags[BIT_W];
        bits.x    = flags[BIT_X];
        bits.u    = flags[BIT_U];
        malformed = !bits.v || (bits.w && !bits.r);
    end
endmodule

// File: rtl/pgf_perm.sv
// Decides whether a leaf grants the rights one access kind needs, and
// whether the user bit blocks a supervisor-effective machine access.
// Assumes the leaf is already known to be well formed.
module pgf_perm
    import pgf_pkg::*;
#(
    parameter bit MXR_EN = 1'b1
) (
    input  acc_kind_e  kind,
    input  leaf_bits_t bits,
    input  logic       mxr,
    input  logic       sum,
    input  logic       mprv,
    input  logic [1:0] mpp,
    output logic       rights_deny,
    output logic       user_deny
);
    logic load_ok;

    // Pick the load rule: with or without the execute-readable override.
    generate
        if (MXR_EN) begin : g_mxr
            assign load_ok = bits.r || (mxr && bits.x);
        end else begin : g_plain
            logic unused_mxr;
            assign unused_mxr = mxr;
            assign load_ok    = bits.r;
        end
    endgenerate

    // Compare the rights the access needs with those the leaf grants.
    always_comb begin
        unique case (kind)
            ACC_FETCH: rights_deny = !bits.x;
            ACC_STORE: rights_deny = !bits.w;
            default:   rights_deny = !load_ok;
        endcase
        user_deny = mprv && (mpp == MPP_SUPER) && bits.u && !sum;
    end
endmodule

// File: rtl/pgf_cause.sv
// Maps an access kind to its page fault cause code.
// Assumes kind 11 is handled as a load.
module pgf_cause
    import pgf_pkg::*;
(
    input  acc_kind_e          kind,
    output logic [CAUSE_W-1:0] cause
);
    // Select the cause code for the kind.
    always_comb begin
        unique case (kind)
            ACC_FETCH: cause = CAUSE_FETCH_PF;
            ACC_STORE: cause = CAUSE_STORE_PF;
            default:   cause = CAUSE_LOAD_PF;
        endcase
    end
endmodule

// File: rtl/pgf_check.sv
// Page fault checker for two-level 32-bit paging. It takes the walk result
// and machine status controls, and returns one registered verdict per
// request, with cause and trap value.
// Assumes the walker has already resolved the leaf. Access faults and
// accessed/dirty handling belong elsewhere.
module pgf_check
    import pgf_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter bit MXR_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic                xlate_on,
    input  logic                walk_hit,
    input  logic [FLAG_W-1:0]   pte_flags,
    input  logic [VA_W-1:0]     vaddr,
    input  logic                st_mxr,
    input  logic                st_sum,
    input  logic                st_mprv,
    input  logic [1:0]          st_mpp,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [CAUSE_W-1:0]  rsp_cause,
    output logic [VA_W-1:0]     rsp_tval
);
    acc_kind_e          kind;
    leaf_bits_t         bits;
    logic               malformed;
    logic               rights_deny;
    logic               user_deny;
    logic [CAUSE_W-1:0] kind_cause;
    logic               leaf_miss;
    logic               leaf_fault;
    logic               fault_d;

    assign kind = acc_kind_e'(req_kind);

    pgf_leaf_decode u_decode (
        .flags     (pte_flags),
        .bits      (bits),
        .malformed (malformed)
    );

    pgf_perm #(.MXR_EN(MXR_EN)) u_perm (
        .kind        (kind),
        .bits        (bits),
        .mxr         (st_mxr),
        .sum         (st_sum),
        .mprv        (st_mprv),
        .mpp         (st_mpp),
        .rights_deny (rights_deny),
        .user_deny   (user_deny)
    );

    pgf_cause u_cause (
        .kind  (kind),
        .cause (kind_cause)
    );

    // Combine the fault classes in priority order; all share one cause.
    always_comb begin
        leaf_miss  = xlate_on && !walk_hit;
        leaf_fault = 1'b0;
        if (xlate_on && walk_hit) begin
            if (malformed)        leaf_fault = 1'b1;
            else if (rights_deny) leaf_fault = 1'b1;
            else if (user_deny)   leaf_fault = 1'b1;
        end
        fault_d = req_valid && (leaf_miss || leaf_fault);
    end

    // Register the verdict, cause and trap value for the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_tval  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= fault_d;
            rsp_cause <= fault_d ? kind_cause : '0;
            rsp_tval  <= fault_d ? vaddr : '0;
        end
    end
endmodule

// File: rtl/pgf_check_sva.sv
// Property checker for pgf_check, attached by bind below.
module pgf_check_sva
    import pgf_pkg::*;
#(
    parameter int VA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_kind,
    input logic                xlate_on,
    input logic                walk_hit,
    input logic [FLAG_W-1:0]   pte_flags,
    input logic [VA_W-1:0]     vaddr,
    input logic                st_mxr,
    input logic                st_sum,
    input logic                st_mprv,
    input logic [1:0]          st_mpp,
    input logic                rsp_valid,
    input logic                rsp_fault,
    input logic [CAUSE_W-1:0]  rsp_cause,
    input logic [VA_W-1:0]     rsp_tval
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_fault); // R1
    AST_CAUSE_BY_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !rsp_fault ||
            rsp_cause == ($past(req_kind) == 2'b00 ? 5'd12 :
                          $past(req_kind) == 2'b10 ? 5'd15 : 5'd13)); // R2
    AST_BARE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xlate_on |=> !rsp_fault); // R3
    AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && xlate_on && !walk_hit |=> rsp_fault); // R4
    AST_BAD_LEAF_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && xlate_on && (!pte_flags[0] || (pte_flags[2] && !pte_flags[1]))
        |=> rsp_fault); // R5
    AST_TVAL_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !rsp_fault || rsp_tval == $past(vaddr)); // R10
    AST_ZERO_WHEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> rsp_cause == '0 && rsp_tval == '0); // R10
    AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid); // R1
endmodule

bind pgf_check pgf_check_sva #(.VA_W(VA_W)) u_sva (.*);

// File: tb/pgf_check_tb.sv
module pgf_check_tb;
    import pgf_pkg::*;

    localparam int VA_W = 32;
    // Row: {kind, xlate, hit, flags UXWRV, mxr, sum, mprv, mpp, exp_fault, exp_cause}
    localparam int ROW_W = 20;
    localparam int NROW  = 24;
    localparam logic [ROW_W-1:0] VEC [NROW] = '{
        {2'd0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 5'd0 },  // R3 bare fetch
        {2'd2, 1'b0, 1'b1, 5'b00000, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 5'd0 },  // R3 bare store junk
        {2'd0, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd12},  // R4 R2 fetch miss
        {2'd1, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd13},  // R4 R2 load miss
        {2'd2, 1'b1, 1'b0, 5'b01111, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd15},  // R4 R2 store miss
        {2'd0, 1'b1, 1'b1, 5'b01000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd12},  // R5 V clear
        {2'd1, 1'b1, 1'b1, 5'b00101, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd13},  // R5 W no R
        {2'd2, 1'b1, 1'b1, 5'b01101, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd15},  // R5 W no R store
        {2'd0, 1'b1, 1'b1, 5'b01001, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 5'd0 },  // R6 X ok
        {2'd0, 1'b1, 1'b1, 5'b00011, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd12},  // R6 no X
        {2'd1, 1'b1, 1'b1, 5'b00011, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 5'd0 },  // R7 R ok
        {2'd1, 1'b1, 1'b1, 5'b01001, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd13},  // R7 X only
        {2'd1, 1'b1, 1'b1, 5'b01001, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 5'd0 },  // R7 X + MXR
        {2'd0, 1'b1, 1'b1, 5'b00011, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 5'd12},  // R6 MXR no help
        {2'd2, 1'b1, 1'b1, 5'b00111, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 5'd0 },  // R8 RW ok
        {2'd2, 1'b1, 1'b1, 5'b01011, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 5'd15},  // R8 no W
        {2'd1, 1'b1, 1'b1, 5'b10011, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 5'd13},  // R9 U no SUM
        {2'd1, 1'b1, 1'b1, 5'b10011, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 5'd0 },  // R9 U SUM
        {2'd1, 1'b1, 1'b1, 5'b10011, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 5'd0 },  // R9 MPP M
        {2'd1, 1'b1, 1'b1, 5'b10011, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 5'd0 },  // R9 MPP U
        {2'd1, 1'b1, 1'b1, 5'b10011, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 5'd0 },  // R9 MPRV off
        {2'd2, 1'b1, 1'b1, 5'b10111, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 5'd15},  // R9 store U
        {2'd3, 1'b1, 1'b1, 5'b00011, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 5'd0 },  // R2 kind3 R
        {2'd3, 1'b1, 1'b1, 5'b01001, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 5'd13}   // R2 kind3 X only
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_valid;
    logic [1:0]          req_kind;
    logic                xlate_on;
    logic                walk_hit;
    logic [FLAG_W-1:0]   pte_flags;
    logic [VA_W-1:0]     vaddr;
    logic                st_mxr;
    logic                st_sum;
    logic                st_mprv;
    logic [1:0]          st_mpp;
    logic                rsp_valid;
    logic                rsp_fault;
    logic [CAUSE_W-1:0]  rsp_cause;
    logic [VA_W-1:0]     rsp_tval;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pgf_check #(.VA_W(VA_W)) u_dut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_kind = 2'd0; xlate_on = 1'b0; walk_hit = 1'b0;
        pte_flags = '0; vaddr = '0; st_mxr = 1'b0; st_sum = 1'b0;
        st_mprv = 1'b0; st_mpp = 2'b00;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        req_valid = 1'b1; xlate_on = 1'b1; vaddr = 32'hdead_beef;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset clears outputs even with a faulting request present
        check("R11 valid", rsp_valid, 0);
        check("R11 fault", rsp_fault, 0);
        check("R11 tval", rsp_tval, 0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROW; i++) begin
            logic [ROW_W-1:0] row;
            logic [VA_W-1:0]  va;
            row = VEC[i];
            va  = 32'h1000_0000 + VA_W'(i) * 32'h0001_2345;
            req_valid = 1'b1;
            req_kind  = row[19:18];
            xlate_on  = row[17];
            walk_hit  = row[16];
            pte_flags = row[15:11];
            st_mxr    = row[10];
            st_sum    = row[9];
            st_mprv   = row[8];
            st_mpp    = row[7:6];
            vaddr     = va;
            @(negedge clk);
            check($sformatf("R1 row%0d valid", i), rsp_valid, 1);
            check($sformatf("R2-R9 row%0d fault", i), rsp_fault, row[5]);
            check($sformatf("R2 row%0d cause", i), rsp_cause, row[4:0]);
            check($sformatf("R10 row%0d tval", i), rsp_tval, row[5] ? va : '0);
        end

        // R1: a fault-worthy request without the strobe yields nothing
        req_valid = 1'b0; xlate_on = 1'b1; walk_hit = 1'b0; vaddr = 32'h1234_5678;
        @(negedge clk);
        check("R1 idle valid", rsp_valid, 0);
        check("R1 idle fault", rsp_fault, 0);
        check("R1 idle cause", rsp_cause, 0);
        check("R1 idle tval", rsp_tval, 0);

        // R11: reset in mid-run over a faulting request
        req_valid = 1'b1; req_kind = 2'd2;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 midrun fault", rsp_fault, 0);
        check("R11 midrun cause", rsp_cause, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 after reset", rsp_fault, 1);
        check("R2 after reset cause", rsp_cause, 15);

        idle_inputs();
        @(negedge clk);
        finish_run();
    end
endmodule